// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block collects requests from sixteen system exception slots and from a parameterised set of peripheral request lines (128 by default). It then presents one winner: the pending, enabled source of highest urgency. The winner is given as an exception number and as a vector-table byte address. Peripheral line n carries exception number 16 + n. The table entry of an exception sits at four times its number, because slot 0 holds the initial stack pointer.

Software or a sequencer programs the block through a one-cycle write port that has three views:
- a set view of the peripheral enables,
- a clear view of the peripheral enables,
- a bank of 3-bit priority fields.

The consumer of the vector pulses `ack_i` while the winner is presented. This retires that source's pending state, and the next winner appears one clock later. Reset, the non-maskable interrupt and hard fault (exceptions 1, 2 and 3) carry fixed ranks above every programmable level.

Top module: `intvec_ctrl`

## Requirements
- R1: Exceptions 1, 2 and 3 have fixed ranks. 1 beats 2, 2 beats 3, and 3 beats any programmable source of any priority value.
- R2: Peripheral line n is presented as exception number 16+n. `vec_addr_o` equals 4 × `exc_num_o`.
- R3: A write with kind 0 (set view) to word w enables peripheral line 32w+b for every bit b of data that is 1. Bits that are 0 change nothing.
- R4: A write with kind 1 (clear view) to word w disables line 32w+b for every data bit b that is 1. Bits that are 0 change nothing. A presented source is always pending and enabled.
- R5: A write with kind 2 to word w loads, for each j in 0..7, data bits [4j+2:4j] as the priority of exception 8w+j. Writes to exceptions 0 to 3 and to reserved numbers are dropped. A lower value is more urgent.
- R6: When two eligible sources have equal rank, the lower exception number is presented.
- R7: `ack_i` while `active_o` is high clears the pending state of the presented source. With no source presented it does nothing. A rising request of the same source at the same edge leaves it pending.
- R8: A request becomes pending only on a low-to-high change of its input. A level held high does not raise it again after an acknowledge.
- R9: A pending peripheral stays pending while it is disabled, and it is presented again once it is re-enabled.
- R10: Exception numbers 0, 7, 8, 9, 10 and 13 are never presented. The live system sources 4, 5, 6, 11, 12, 14 and 15 need no enable.
- R11: After reset nothing is pending, every line is disabled, every priority is 0, and the outputs read inactive, 0, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_req_i | input | 16 | Request levels of system exceptions 0..15 |
| irq_req_i | input | NUM_IRQ | Request levels of the peripheral lines |
| wr_en_i | input | 1 | Write strobe |
| wr_kind_i | input | 2 | 0 set-enable, 1 clear-enable, 2 priority, 3 no effect |
| wr_word_i | input | WIDX_W (5) | Word index inside the selected view |
| wr_data_i | input | 32 | Write data |
| ack_i | input | 1 | Retire the presented source |
| active_o | output | 1 | A source is presented |
| exc_num_o | output | EXC_W (8) | Presented exception number, 0 when inactive |
| vec_addr_o | output | EXC_W+2 (10) | Vector-table byte address of the presented source |

## Verification
All state sits in registers, and the outputs are decoded combinationally from that state. So a request edge, an enable or priority write, or an acknowledge that is sampled at one rising edge changes the outputs right after that edge. Its result is due within the same clock. The bench drives every stimulus at a falling edge and advances its behavioural model at the next rising edge. It then compares active flag, number and address at the following falling edge, once per clock. Hand-worked expectations with requirement tags are checked at the same point. After reset the bench waits out the two-stage reset release before it applies any stimulus.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int SYS_CNT         = 16;
  localparam int FIXED_CNT       = 3;
  localparam int DATA_W          = 32;
  localparam int PRIO_W          = 3;
  localparam int FIELD_STRIDE    = 4;
  localparam int FIELDS_PER_WORD = DATA_W / FIELD_STRIDE;
  localparam int RANK_W          = PRIO_W + 1;
  // system exception numbers that can ever request: 1..6, 11, 12, 14, 15
  localparam logic [SYS_CNT-1:0] SYS_LIVE = 16'hD87E;

  typedef enum logic [1:0] {
    WK_SET  = 2'd0,
    WK_CLR  = 2'd1,
    WK_PRIO = 2'd2,
    WK_NONE = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/ivc_pending.sv
module ivc_pending #(
  parameter int NUM_EXC = 144,
  parameter int EXC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXC-1:0] req_i,
  input  logic               clr_i,
  input  logic [EXC_W-1:0]   clr_num_i,
  output logic [NUM_EXC-1:0] pend_o
);
  logic [NUM_EXC-1:0] req_q, pend_q, pend_d, rise, clr_vec;
  logic               pend_upd;

  always_comb begin
    rise    = req_i & ~req_q;
    clr_vec = '0;
    if (clr_i) clr_vec[clr_num_i] = 1'b1;
    pend_d   = (pend_q & ~clr_vec) | rise;
    pend_upd = clr_i | (|rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q <= req_i;
      if (pend_upd) pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ivc_enable.sv
module ivc_enable #(
  parameter int NUM_IRQ = 128,
  parameter int WIDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_set_i,
  input  logic              wr_clr_i,
  input  logic [WIDX_W-1:0] wr_word_i,
  input  logic [31:0]       wr_data_i,
  output logic [NUM_IRQ-1:0] en_o
);
  logic [NUM_IRQ-1:0] en_q, en_d, set_m, clr_m;
  logic               wr_any;

  for (genvar b = 0; b < NUM_IRQ; b++) begin : g_bit
    localparam logic [WIDX_W-1:0] WSEL = WIDX_W'(b / 32);
    localparam int                BPOS = b % 32;
    assign set_m[b] = wr_set_i & (wr_word_i == WSEL) & wr_data_i[BPOS];
    assign clr_m[b] = wr_clr_i & (wr_word_i == WSEL) & wr_data_i[BPOS];
  end

  always_comb begin
    en_d   = (en_q | set_m) & ~clr_m;
    wr_any = wr_set_i | wr_clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_any) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
  parameter int NUM_EXC = 144,
  parameter int WIDX_W  = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_i,
  input  logic [WIDX_W-1:0]                  wr_word_i,
  input  logic [31:0]                        wr_data_i,
  output logic [NUM_EXC*ivc_pkg::PRIO_W-1:0] prio_o
);
  import ivc_pkg::*;

  logic unused_data;
  assign unused_data = ^wr_data_i;

  for (genvar e = 0; e < NUM_EXC; e++) begin : g_exc
    localparam bit PROG = (e >= SYS_CNT) ? 1'b1
                        : ((e > FIXED_CNT) && SYS_LIVE[e % SYS_CNT]);
    if (PROG) begin : g_prog
      localparam logic [WIDX_W-1:0] WSEL = WIDX_W'(e / FIELDS_PER_WORD);
      localparam int                FLO  = (e % FIELDS_PER_WORD) * FIELD_STRIDE;
      logic [PRIO_W-1:0] pq, pd;
      logic              ld;
      always_comb begin
        ld = wr_i & (wr_word_i == WSEL);
        pd = wr_data_i[FLO +: PRIO_W];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pq <= '0;
        else if (ld) pq <= pd;
      end
      assign prio_o[e*PRIO_W +: PRIO_W] = pq;
    end else begin : g_fixed
      assign prio_o[e*PRIO_W +: PRIO_W] = '0;
    end
  end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int NUM_EXC = 144,
  parameter int EXC_W   = 8
) (
  input  logic [NUM_EXC-1:0]                 elig_i,
  input  logic [NUM_EXC*ivc_pkg::PRIO_W-1:0] prio_i,
  output logic                               found_o,
  output logic [EXC_W-1:0]                   num_o
);
  import ivc_pkg::*;

  logic [RANK_W-1:0] rank [NUM_EXC];

  for (genvar e = 0; e < NUM_EXC; e++) begin : g_rank
    if (e == 0) begin : g_zero
      assign rank[e] = '1;
    end else if (e <= FIXED_CNT) begin : g_fix
      assign rank[e] = RANK_W'(e - 1);
    end else begin : g_prg
      assign rank[e] = RANK_W'(FIXED_CNT) + RANK_W'(prio_i[e*PRIO_W +: PRIO_W]);
    end
  end

  logic [RANK_W-1:0] best_rank;

  always_comb begin
    found_o   = 1'b0;
    num_o     = '0;
    best_rank = '1;
    for (int e = 0; e < NUM_EXC; e++) begin
      if (elig_i[e] && (!found_o || (rank[e] < best_rank))) begin
        found_o   = 1'b1;
        best_rank = rank[e];
        num_o     = EXC_W'(e);
      end
    end
  end
endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl #(
  parameter int NUM_IRQ = 128,
  localparam int NUM_EXC = ivc_pkg::SYS_CNT + NUM_IRQ,
  localparam int EXC_W   = $clog2(NUM_EXC),
  localparam int WIDX_W  = $clog2((NUM_EXC + ivc_pkg::FIELDS_PER_WORD - 1) / ivc_pkg::FIELDS_PER_WORD)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        sys_req_i,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_kind_i,
  input  logic [WIDX_W-1:0]  wr_word_i,
  input  logic [31:0]        wr_data_i,
  input  logic               ack_i,
  output logic               active_o,
  output logic [EXC_W-1:0]   exc_num_o,
  output logic [EXC_W+1:0]   vec_addr_o
);
  import ivc_pkg::*;

  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  wr_kind_e                     kind;
  logic                         wr_set, wr_clr, wr_prio, found, retire;
  logic [NUM_EXC-1:0]           req_all, pend, en_mask, elig;
  logic [NUM_IRQ-1:0]           en_irq;
  logic [NUM_EXC*PRIO_W-1:0]    prio;
  logic [EXC_W-1:0]             win;

  always_comb begin
    kind    = wr_kind_e'(wr_kind_i);
    wr_set  = wr_en_i && (kind == WK_SET);
    wr_clr  = wr_en_i && (kind == WK_CLR);
    wr_prio = wr_en_i && (kind == WK_PRIO);
    req_all = {irq_req_i, sys_req_i & SYS_LIVE};
    en_mask = {en_irq, SYS_LIVE};
    elig    = pend & en_mask;
    retire  = ack_i & found;
  end

  ivc_pending #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W)) u_pend (
    .clk(clk), .rst_n(rst_s), .req_i(req_all),
    .clr_i(retire), .clr_num_i(win), .pend_o(pend));

  ivc_enable #(.NUM_IRQ(NUM_IRQ), .WIDX_W(WIDX_W)) u_en (
    .clk(clk), .rst_n(rst_s), .wr_set_i(wr_set), .wr_clr_i(wr_clr),
    .wr_word_i(wr_word_i), .wr_data_i(wr_data_i), .en_o(en_irq));

  ivc_prio #(.NUM_EXC(NUM_EXC), .WIDX_W(WIDX_W)) u_prio (
    .clk(clk), .rst_n(rst_s), .wr_i(wr_prio),
    .wr_word_i(wr_word_i), .wr_data_i(wr_data_i), .prio_o(prio));

  ivc_arbiter #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W)) u_arb (
    .elig_i(elig), .prio_i(prio), .found_o(found), .num_o(win));

  assign active_o   = found;
  assign exc_num_o  = found ? win : '0;
  assign vec_addr_o = {exc_num_o, 2'b00};
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int NUM_EXC = 144,
  parameter int EXC_W   = 8,
  localparam int NUM_IRQ = NUM_EXC - ivc_pkg::SYS_CNT
) (
  input logic               clk,
  input logic               rst_n,
  input logic [15:0]        sys_req_i,
  input logic [NUM_IRQ-1:0] irq_req_i,
  input logic               ack_i,
  input logic               active_o,
  input logic [EXC_W-1:0]   exc_num_o,
  input logic [NUM_EXC-1:0] pend_i,
  input logic [NUM_EXC-1:0] en_i
);
  import ivc_pkg::*;

  logic [NUM_EXC-1:0] req_all, req_prev;
  logic               rerise;
  assign req_all = {irq_req_i, sys_req_i & SYS_LIVE};
  assign rerise  = req_all[exc_num_o] & ~req_prev[exc_num_o];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_prev <= '0;
    else        req_prev <= req_all;
  end

  a_r1_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pend_i[1] |-> (active_o && exc_num_o == EXC_W'(1)));

  a_r1_nmi_over_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i[2] && !pend_i[1]) |-> (active_o && exc_num_o == EXC_W'(2)));

  a_r4_sel_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (pend_i[exc_num_o] && en_i[exc_num_o]));

  a_r7_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && active_o && !rerise) |=> !(active_o && exc_num_o == $past(exc_num_o)));

  a_r9_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> ((pend_i & $past(pend_i)) == $past(pend_i)));

  a_r10_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (exc_num_o >= EXC_W'(SYS_CNT) || SYS_LIVE[exc_num_o[3:0]]));
endmodule

bind intvec_ctrl ivc_checker #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .sys_req_i(sys_req_i), .irq_req_i(irq_req_i),
  .ack_i(ack_i), .active_o(active_o), .exc_num_o(exc_num_o),
  .pend_i(pend), .en_i(en_mask));

// File: tb/tb_intvec_ctrl.sv
`timescale 1ns/1ps
module tb_intvec_ctrl;
  localparam int NIRQ = 128;
  localparam int NEXC = 16 + NIRQ;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic [15:0]     sysreq;
  logic [NIRQ-1:0] irqreq;
  logic            wr_en, ack;
  logic [1:0]      wr_kind;
  logic [4:0]      wr_word;
  logic [31:0]     wr_data;
  logic            active;
  logic [7:0]      excn;
  logic [9:0]      vaddr;

  intvec_ctrl #(.NUM_IRQ(NIRQ)) dut (
    .clk(clk), .rst_n(rst_n), .sys_req_i(sysreq), .irq_req_i(irqreq),
    .wr_en_i(wr_en), .wr_kind_i(wr_kind), .wr_word_i(wr_word), .wr_data_i(wr_data),
    .ack_i(ack), .active_o(active), .exc_num_o(excn), .vec_addr_o(vaddr));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit m_pend [NEXC];
  bit m_prev [NEXC];
  bit m_en   [NIRQ];
  int m_prio [NEXC];

  function automatic bit live(int n);
    if (n >= 16) return 1'b1;
    return (n inside {[1:6], 11, 12, 14, 15});
  endfunction

  function automatic bit m_req(int n);
    if (n < 16) return sysreq[n];
    return irqreq[n-16];
  endfunction

  function automatic int m_sel();
    int best = 0;
    int brank = 1000;
    for (int n = 1; n < NEXC; n++) begin
      bit ok = m_pend[n] && (n < 16 ? live(n) : m_en[n-16]);
      int rk = (n <= 3) ? n - 1 : 3 + m_prio[n];
      if (ok && rk < brank) begin
        best = n;
        brank = rk;
      end
    end
    return best;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_sel(string tag, int exp);
    check(tag, active ? int'(excn) : 0, exp);
  endtask

  task automatic tick();
    int s;
    s = m_sel();
    @(posedge clk);
    #1;
    if (ack && s > 0) m_pend[s] = 1'b0;
    for (int n = 0; n < NEXC; n++) begin
      bit r = live(n) && (n != 0) && m_req(n);
      if (r && !m_prev[n]) m_pend[n] = 1'b1;
      m_prev[n] = r;
    end
    if (wr_en && wr_kind == 2'd0)
      for (int b = 0; b < 32; b++) if (wr_data[b] && 32*wr_word + b < NIRQ) m_en[32*wr_word+b] = 1'b1;
    if (wr_en && wr_kind == 2'd1)
      for (int b = 0; b < 32; b++) if (wr_data[b] && 32*wr_word + b < NIRQ) m_en[32*wr_word+b] = 1'b0;
    if (wr_en && wr_kind == 2'd2)
      for (int j = 0; j < 8; j++) begin
        int e = 8*wr_word + j;
        if (e < NEXC && e > 3 && live(e)) m_prio[e] = int'((wr_data >> (4*j)) & 32'd7);
      end
    @(negedge clk);
    s = m_sel();
    check("R2 model active", int'(active), (s > 0) ? 1 : 0);
    check("R2 model exc_num", int'(excn), s);
    check("R2 model vec_addr", int'(vaddr), 4*s);
    wr_en = 1'b0;
    ack   = 1'b0;
  endtask

  task automatic wr(int kind, int word, logic [31:0] data);
    wr_en = 1'b1; wr_kind = 2'(kind); wr_word = 5'(word); wr_data = data;
    tick();
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sysreq = '0; irqreq = '0; wr_en = 1'b0; ack = 1'b0;
    wr_kind = '0; wr_word = '0; wr_data = '0;
    for (int n = 0; n < NEXC; n++) begin m_pend[n] = 0; m_prev[n] = 0; m_prio[n] = 0; end
    for (int n = 0; n < NIRQ; n++) m_en[n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    // R11 reset state
    check("R11 active after reset", int'(active), 0);
    check("R11 exc_num after reset", int'(excn), 0);
    check("R11 vec_addr after reset", int'(vaddr), 0);

    // R9 / R3: pending but disabled is not presented
    irqreq[5] = 1'b1; tick();
    expect_sel("R9 disabled line hidden", 0);
    wr(0, 0, 32'h0);
    expect_sel("R3 zero set bits no effect", 0);
    wr(0, 0, 32'h20);
    expect_sel("R3 set enable line 5", 21);
    check("R2 vec addr line 5", int'(vaddr), 84);
    wr(1, 0, 32'h0);
    expect_sel("R4 zero clear bits no effect", 21);

    // R6 tie, R5 priority
    irqreq[127] = 1'b1; tick();
    wr(0, 3, 32'h8000_0000);
    expect_sel("R6 tie lower number", 21);
    wr(2, 17, 32'h1000_0000);
    expect_sel("R5 prio 1 loses to prio 0", 21);
    wr(2, 2, 32'h0030_0000);
    expect_sel("R5 lower value wins", 143);
    check("R2 vec addr line 127", int'(vaddr), 572);

    // R7 / R8
    do_ack();
    expect_sel("R7 ack retires 143", 21);
    tick();
    expect_sel("R8 held level no re-pend", 21);
    irqreq[127] = 1'b0; tick();
    irqreq[127] = 1'b1; tick();
    expect_sel("R8 new edge pends", 143);

    // R4 / R9
    wr(1, 3, 32'h8000_0000);
    expect_sel("R4 clear enable hides 143", 21);
    do_ack();
    expect_sel("R7 ack retires 21", 0);
    wr(0, 3, 32'h8000_0000);
    expect_sel("R9 pending kept while disabled", 143);

    // R1 fixed ranks
    sysreq[3] = 1'b1; tick();
    expect_sel("R1 hard fault over programmable", 3);
    sysreq[2] = 1'b1; tick();
    expect_sel("R1 nmi over hard fault", 2);
    sysreq[1] = 1'b1; tick();
    expect_sel("R1 reset over all", 1);
    do_ack(); expect_sel("R1 after reset ack", 2);
    do_ack(); expect_sel("R1 after nmi ack", 3);
    do_ack(); expect_sel("R1 after fault ack", 143);

    // R10 reserved and live system sources
    sysreq[7] = 1'b1; sysreq[0] = 1'b1; sysreq[13] = 1'b1; tick();
    expect_sel("R10 reserved never presented", 143);
    sysreq[11] = 1'b1; tick();
    expect_sel("R10 live system source needs no enable", 11);
    do_ack(); expect_sel("R10 back to 143", 143);
    do_ack(); expect_sel("R7 all retired", 0);

    // R7 idle ack, ack with same-cycle rise
    do_ack(); expect_sel("R7 idle ack no effect", 0);
    irqreq[5] = 1'b0; tick();
    irqreq[5] = 1'b1; tick();
    expect_sel("R8 line 5 new edge", 21);
    irqreq[5] = 1'b0; tick();
    irqreq[5] = 1'b1; ack = 1'b1; tick();
    expect_sel("R7 rise with ack keeps pending", 21);
    do_ack(); expect_sel("R7 final retire", 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule